// File: doc/BRIEF.md
# Lowpass and Notch Controller Cascade

This block is a discrete-time feedback compensator for a positioning loop that has to keep a lightly damped liquid-sloshing mode at about 1.937 Hz from being excited. Each error sample passes through a first-order lowpass section with a large DC gain. The result then passes through a second-order notch section. The notch zeros sit almost on the unit circle at the sloshing frequency, and its poles are critically damped at the same frequency. The notch therefore has unity gain at DC and removes a narrow band around the mode.

Samples are signed fixed point with one sign bit, 15 integer bits and 24 fraction bits, which is 40 bits in all. A new sample arrives with a one-cycle strobe at the loop's 512 Hz rate, or at any slower pace the system chooses. The filtered sample appears one clock later with its own strobe and is held until the next one. All coefficients are constants. They are derived at elaboration by the bilinear transform from the continuous-time gain, time constant, notch frequency and damping values, so nothing in the datapath is programmable.

Top module: `lpnotch_top`

## Requirements
- R1: While srst is high at a clock edge, outValid is 0 and outData is 0 from the next cycle on.
- R2: outValid is high in exactly those cycles that follow a clock edge at which inValid was high and srst was low. Each such pulse carries one new output sample.
- R3: A data word is the signed integer value divided by 2^24. Output sample n equals, within 2e-3 + 1e-4·|y|, the cascade of the lowpass 16.57/(0.053s+1) and the notch (s²+2·0.0001·ω·s+ω²)/(s²+2·ω·s+ω²), with ω = 2π·1.937 rad/s. Both sections are discretised by the bilinear transform at 512 Hz and start from zero state.
- R4: A constant input x settles to 16.57·x within 2e-3 after 2500 samples.
- R5: A sustained unit-amplitude sine at 1.937 Hz, sampled at 512 Hz, gives an output magnitude below 0.5 from sample 2200 onward. An unattenuated output would be near 13.9.
- R6: When the result exceeds the positive range, the output clips at the largest word 0x7FFFFFFFFF and stays non-negative. A constant input of +3000 drives the output above 32767.5 and never produces a negative word.
- R7: When the result exceeds the negative range, the output clips at the smallest word 0x8000000000 and stays non-positive. A constant input of -3000 drives the output below -32767.5 and never produces a positive word.
- R8: Cycles with inValid low do not advance the filter. outData holds its value, and the later responses equal those of the same samples sent without gaps.
- R9: Reset clears all filter history. The first zero sample after reset gives exactly 0, and the samples that follow match a zero-state response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inData | input | 40 | Error sample, signed, 24 fraction bits |
| outValid | output | 1 | Output sample strobe |
| outData | output | 40 | Control sample, signed, 24 fraction bits, held between strobes |

## Verification
Every output sample is due in the cycle after the clock edge that captured its input strobe, and it must then hold through any idle cycles. The bench drives each input on a falling edge and reads the result on the next falling edge. That reading sits half a period after the capturing rising edge. In each gap cycle it confirms that the strobe is low and that the word has not changed. Long constant and sinusoidal runs are sent back to back, one sample per cycle, so that settling, notch depth and clipping are each judged at a known sample index.

// File: rtl/lpnotch_pkg.sv
`timescale 1ns/1ps
package lpnotch_pkg;

  // Coefficient word: sign, two integer bits, fraction bits set per instance.
  // The fraction width must stay at or below 29 to fit the 32-bit converter.
  localparam int COEF_W = 32;
  localparam real PI = 3.14159265358979323846;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero all history registers
    logic advance;  // accept inData and shift the delay lines
  } lpnStrobe_t;

  // Round a real coefficient to the nearest fixed-point code
  function automatic coef_t toCoef(real v, int fracBits);
    real scaled;
    scaled = v * (2.0 ** fracBits);
    if (scaled >= 0.0) scaled = scaled + 0.5;
    else               scaled = scaled - 0.5;
    return coef_t'($rtoi(scaled));
  endfunction

endpackage

// File: rtl/lpnotch_mac.sv
`timescale 1ns/1ps
// Sum of constant-coefficient products, one rounding, then clip to DATA_W.
module lpnotch_mac
  import lpnotch_pkg::*;
#(
  parameter int NTAP    = 3,
  parameter int DATA_W  = 40,
  parameter int CFRAC_W = 29,
  parameter logic [NTAP*COEF_W-1:0] COEFS = '0
) (
  input  logic [NTAP*DATA_W-1:0]  taps,
  output logic signed [DATA_W-1:0] result
);
  localparam int PROD_W  = DATA_W + COEF_W;
  localparam int GUARD_W = $clog2(NTAP) + 1;
  localparam int ACC_W   = PROD_W + GUARD_W;
  localparam int TOP_W   = ACC_W - DATA_W + 1;

  logic signed [ACC_W-1:0] prodExt [NTAP];

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    logic signed [DATA_W-1:0] sampV;
    logic signed [COEF_W-1:0] coefV;
    logic signed [PROD_W-1:0] sampX;
    logic signed [PROD_W-1:0] coefX;
    logic signed [PROD_W-1:0] prodV;
    assign sampV = taps[i*DATA_W +: DATA_W];
    assign coefV = COEFS[i*COEF_W +: COEF_W];
    assign sampX = PROD_W'(sampV);
    assign coefX = PROD_W'(coefV);
    assign prodV = sampX * coefX;
    assign prodExt[i] = ACC_W'(prodV);
  end

  logic signed [ACC_W-1:0] accSum;
  logic signed [ACC_W-1:0] accRnd;
  logic signed [ACC_W-1:0] accShr;
  logic        [TOP_W-1:0] topBits;

  always_comb begin
    accSum = '0;
    for (int i = 0; i < NTAP; i++) begin
      accSum = accSum + prodExt[i];
    end
  end

  // Round half up at the coefficient fraction point, then drop it
  assign accRnd  = accSum + (ACC_W'(1) <<< (CFRAC_W - 1));
  assign accShr  = accRnd >>> CFRAC_W;
  assign topBits = accShr[ACC_W-1:DATA_W-1];

  always_comb begin
    if (topBits == '0 || topBits == '1) begin
      result = accShr[DATA_W-1:0];
    end else if (accShr[ACC_W-1]) begin
      result = {1'b1, {(DATA_W-1){1'b0}}};
    end else begin
      result = {1'b0, {(DATA_W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/lpnotch_ctrl.sv
`timescale 1ns/1ps
// Turns the input strobe and reset into datapath strobes and the output strobe.
module lpnotch_ctrl
  import lpnotch_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       inValid,
  output lpnStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.clear   = srst;
    strobe.advance = inValid & ~srst;
  end

  always_ff @(posedge clk) begin
    if (srst) outValid <= 1'b0;
    else      outValid <= inValid;
  end

endmodule

// File: rtl/lpnotch_datapath.sv
`timescale 1ns/1ps
// Lowpass then notch, both direct form I.
// The lowpass output history doubles as the notch input history.
module lpnotch_datapath
  import lpnotch_pkg::*;
#(
  parameter int  DATA_W    = 40,
  parameter int  CFRAC_W   = 29,
  parameter real GAIN      = 16.57,
  parameter real TAU_S     = 0.053,
  parameter real NOTCH_HZ  = 1.937,
  parameter real ZETA_ZERO = 0.0001,
  parameter real ZETA_POLE = 1.0,
  parameter real SAMPLE_HZ = 512.0
) (
  input  logic                     clk,
  input  lpnStrobe_t               strobe,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [DATA_W-1:0] outData
);
  // Bilinear substitution s = K (1 - z^-1) / (1 + z^-1)
  localparam real K     = 2.0 * SAMPLE_HZ;
  localparam real W     = 2.0 * PI * NOTCH_HZ;
  localparam real KK    = K * K;
  localparam real WW    = W * W;

  // Lowpass section
  localparam real LP_DEN = TAU_S * K + 1.0;
  localparam real LP_B   = GAIN / LP_DEN;
  localparam real LP_A1  = (1.0 - TAU_S * K) / LP_DEN;

  // Notch section
  localparam real ND0 = KK + 2.0 * ZETA_POLE * W * K + WW;
  localparam real ND1 = 2.0 * WW - 2.0 * KK;
  localparam real ND2 = KK - 2.0 * ZETA_POLE * W * K + WW;
  localparam real NN0 = KK + 2.0 * ZETA_ZERO * W * K + WW;
  localparam real NN1 = 2.0 * WW - 2.0 * KK;
  localparam real NN2 = KK - 2.0 * ZETA_ZERO * W * K + WW;

  localparam logic [3*COEF_W-1:0] LP_COEFS = {
    toCoef(-LP_A1, CFRAC_W),
    toCoef(LP_B, CFRAC_W),
    toCoef(LP_B, CFRAC_W)
  };

  localparam logic [5*COEF_W-1:0] NT_COEFS = {
    toCoef(-ND2 / ND0, CFRAC_W),
    toCoef(-ND1 / ND0, CFRAC_W),
    toCoef(NN2 / ND0, CFRAC_W),
    toCoef(NN1 / ND0, CFRAC_W),
    toCoef(NN0 / ND0, CFRAC_W)
  };

  logic signed [DATA_W-1:0] xDly;
  logic signed [DATA_W-1:0] lpOut;
  logic signed [DATA_W-1:0] lpDly1;
  logic signed [DATA_W-1:0] lpDly2;
  logic signed [DATA_W-1:0] ntOut;
  logic signed [DATA_W-1:0] ntDly1;
  logic signed [DATA_W-1:0] ntDly2;

  lpnotch_mac #(
    .NTAP   (3),
    .DATA_W (DATA_W),
    .CFRAC_W(CFRAC_W),
    .COEFS  (LP_COEFS)
  ) lpMac_i (
    .taps  ({lpDly1, xDly, inData}),
    .result(lpOut)
  );

  lpnotch_mac #(
    .NTAP   (5),
    .DATA_W (DATA_W),
    .CFRAC_W(CFRAC_W),
    .COEFS  (NT_COEFS)
  ) ntMac_i (
    .taps  ({ntDly2, ntDly1, lpDly2, lpDly1, lpOut}),
    .result(ntOut)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      xDly   <= '0;
      lpDly1 <= '0;
      lpDly2 <= '0;
      ntDly1 <= '0;
      ntDly2 <= '0;
    end else if (strobe.advance) begin
      xDly   <= inData;
      lpDly1 <= lpOut;
      lpDly2 <= lpDly1;
      ntDly1 <= ntOut;
      ntDly2 <= ntDly1;
    end
  end

  // The newest notch result is the held output sample
  assign outData = ntDly1;

endmodule

// File: rtl/lpnotch_top.sv
`timescale 1ns/1ps
module lpnotch_top
  import lpnotch_pkg::*;
#(
  parameter int  DATA_W    = 40,
  parameter int  CFRAC_W   = 29,
  parameter real GAIN      = 16.57,
  parameter real TAU_S     = 0.053,
  parameter real NOTCH_HZ  = 1.937,
  parameter real ZETA_ZERO = 0.0001,
  parameter real ZETA_POLE = 1.0,
  parameter real SAMPLE_HZ = 512.0
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  lpnStrobe_t strobe;

  lpnotch_ctrl ctrl_i (
    .clk     (clk),
    .srst    (srst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  lpnotch_datapath #(
    .DATA_W   (DATA_W),
    .CFRAC_W  (CFRAC_W),
    .GAIN     (GAIN),
    .TAU_S    (TAU_S),
    .NOTCH_HZ (NOTCH_HZ),
    .ZETA_ZERO(ZETA_ZERO),
    .ZETA_POLE(ZETA_POLE),
    .SAMPLE_HZ(SAMPLE_HZ)
  ) dp_i (
    .clk    (clk),
    .strobe (strobe),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: rtl/lpnotch_checker.sv
`timescale 1ns/1ps
module lpnotch_checker #(
  parameter int DATA_W = 40
) (
  input logic              clk,
  input logic              srst,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic [DATA_W-1:0] outData
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    srst |=> (!outValid && outData == '0));

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (srst)
    inValid |=> outValid);

  // R2
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (srst)
    !inValid |=> !outValid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (!outValid && !$past(srst)) |-> $stable(outData));

  // R9
  fresh_zero_chk: assert property (@(posedge clk) disable iff (srst)
    ($past(srst) && inValid && inData == '0) |=> outData == '0);

endmodule

bind lpnotch_top lpnotch_checker #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .srst    (srst),
  .inValid (inValid),
  .inData  (inData),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/lpnotch_top_tb_top.sv
`timescale 1ns/1ps
module lpnotch_top_tb_top;

  localparam real SCALE = 16777216.0;  // 2^24
  localparam int  NVEC  = 16;
  // Stimulus in sixteenths of a unit
  localparam int STIM_Q4 [NVEC] = '{16, 8, -32, 52, 0, 0, -24, 160,
                                    -160, 64, 3, -7, 100, -100, 1, 0};

  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic        inValid = 1'b0;
  logic [39:0] inData = '0;
  logic        outValid;
  logic [39:0] outData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lpnotch_top dut_i (
    .clk     (clk),
    .srst    (srst),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

  // Ideal real-valued model of the bilinear cascade
  real cB, cA1, cN0, cN1, cN2, cD1, cD2;
  real mX1, mL1, mL2, mN1, mN2, mExp;

  task automatic modelInit();
    real k, w, d0;
    k   = 1024.0;
    w   = 2.0 * 3.14159265358979323846 * 1.937;
    cB  = 16.57 / (0.053 * k + 1.0);
    cA1 = (1.0 - 0.053 * k) / (0.053 * k + 1.0);
    d0  = k * k + 2.0 * w * k + w * w;
    cN0 = (k * k + 2.0 * 0.0001 * w * k + w * w) / d0;
    cN1 = (2.0 * w * w - 2.0 * k * k) / d0;
    cN2 = (k * k - 2.0 * 0.0001 * w * k + w * w) / d0;
    cD1 = (2.0 * w * w - 2.0 * k * k) / d0;
    cD2 = (k * k - 2.0 * w * k + w * w) / d0;
  endtask

  task automatic modelClear();
    mX1 = 0.0; mL1 = 0.0; mL2 = 0.0; mN1 = 0.0; mN2 = 0.0; mExp = 0.0;
  endtask

  task automatic modelStep(input real x);
    real l, n;
    l = cB * (x + mX1) - cA1 * mL1;
    n = cN0 * l + cN1 * mL1 + cN2 * mL2 - cD1 * mN1 - cD2 * mN2;
    mX1 = x; mL2 = mL1; mL1 = l; mN2 = mN1; mN1 = n; mExp = n;
  endtask

  function automatic real toReal(input logic [39:0] f);
    longint lv;
    lv = longint'($signed(f));
    return real'(lv) / SCALE;
  endfunction

  function automatic logic [39:0] toFix(input real v);
    return 40'(longint'(v * SCALE));
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic checkReal(input string req, input real act, input real exp, input real tol);
    checks++;
    if (absr(act - exp) > tol) begin
      errors++;
      $display("FAIL %s: actual %f expected %f", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the falling edge where the result is read
  task automatic sendSample(input logic [39:0] f, input int gap, input bit cmp, input string req);
    logic [39:0] held;
    inValid = 1'b1;
    inData  = f;
    @(negedge clk);
    inValid = 1'b0;
    modelStep(toReal(f));
    checkBit("R2 strobe", outValid, 1'b1);
    if (cmp) checkReal(req, toReal(outData), mExp, 2.0e-3 + 1.0e-4 * absr(mExp));
    held = outData;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      checkBit("R8 strobe low", outValid, 1'b0);
      checkBit("R8 hold", outData == held, 1'b1);
    end
  endtask

  task automatic doReset();
    srst    = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    srst = 1'b0;
    modelClear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    real peak;
    real v;
    logic [39:0] satPos;
    logic [39:0] satNeg;
    modelInit();
    modelClear();
    satPos = 40'(3000) << 24;
    satNeg = -satPos;

    // R1: reset state
    repeat (3) @(negedge clk);
    checkBit("R1 outValid", outValid, 1'b0);
    checkReal("R1 outData", toReal(outData), 0.0, 0.0);
    srst = 1'b0;
    @(negedge clk);

    // R3, R8: vector table with idle gaps of 0 to 2 cycles
    for (int i = 0; i < NVEC; i++) begin
      sendSample(40'(STIM_Q4[i]) <<< 20, i % 3, 1'b1, "R3 table");
    end

    // R9: mid-run reset clears history
    doReset();
    checkBit("R9 outValid", outValid, 1'b0);
    checkReal("R9 cleared", toReal(outData), 0.0, 0.0);
    sendSample('0, 1, 1'b0, "R9");
    checkReal("R9 zero in", toReal(outData), 0.0, 0.0);
    sendSample(toFix(1.0), 0, 1'b1, "R9 fresh");
    sendSample(toFix(-0.5), 2, 1'b1, "R9 fresh");

    // R4: DC settling, back to back
    doReset();
    for (int n = 0; n < 2500; n++) sendSample(toFix(1.5), 0, (n % 50) == 0, "R3 step");
    checkReal("R4 dc gain", toReal(outData), 16.57 * 1.5, 2.0e-3);

    // R5: sine at the notch frequency
    doReset();
    peak = 0.0;
    for (int n = 0; n < 2500; n++) begin
      v = $sin(2.0 * 3.14159265358979323846 * 1.937 * real'(n) / 512.0);
      sendSample(toFix(v), 0, (n % 25) == 0, "R3 sine");
      if (n >= 2200 && absr(toReal(outData)) > peak) peak = absr(toReal(outData));
    end
    checkBit("R5 notch depth", peak < 0.5, 1'b1);
    if (peak >= 0.5) $display("FAIL R5: actual %f expected below 0.5", peak);

    // R6: positive clipping
    doReset();
    for (int n = 0; n < 2500; n++) begin
      sendSample(satPos, 0, 1'b0, "R6");
      if (n % 100 == 0) checkBit("R6 no wrap", outData[39], 1'b0);
    end
    checkBit("R6 clip level", toReal(outData) > 32767.5, 1'b1);

    // R7: negative clipping
    doReset();
    for (int n = 0; n < 2500; n++) begin
      sendSample(satNeg, 0, 1'b0, "R7");
      if (n % 100 == 0 && n > 0) checkBit("R7 no wrap", outData[39], 1'b1);
    end
    checkBit("R7 clip level", toReal(outData) < -32767.5, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule